// File: doc/BRIEF.md
# Link Rate Change Sequencer

This block walks a display transmitter PHY through a link-rate change without software stepping each field. A one-cycle start pulse carries a rate code, a lane count and a spread-spectrum request. The sequencer checks them first; a bad request ends at once with an error and leaves every PHY control field as it was. A good request parks and powers down all lanes, waits a settle time, powers the PLL down, loads the divider set for the chosen rate, sets or clears spread spectrum, powers the PLL back up, wakes the active lanes, then polls the PLL ready input. When ready is seen, the lanes leave idle. When it is not seen within the timeout, the sequence stops with a timeout error.

The FSM states are ST_IDLE (waiting for start), ST_SETTLE (lanes parked, timing the settle delay), ST_PROGRAM (rate and spread-spectrum load), ST_POWERUP (PLL and active-lane power-up), ST_POLL (sampling ready once per poll interval), ST_RELEASE (releasing lanes) and ST_FAIL (timeout report). The transitions are: IDLE to SETTLE on an accepted start; SETTLE to PROGRAM when the settle timer expires; PROGRAM to POWERUP and POWERUP to POLL after one cycle each; POLL to RELEASE when ready is seen at a poll tick; POLL to FAIL when the last allowed poll tick sees no ready; RELEASE and FAIL back to IDLE after one cycle. A rejected start does not leave IDLE.

Timing comes from the parameter `CYC_PER_US`, which gives clock cycles per microsecond. The settle delay, poll interval and timeout are given in microseconds.

Top module: `lrs_seq`

## Requirements
- R1: Rate code 0 selects 1.62 Gb/s and code 1 selects 2.7 Gb/s. Codes 2 and 3 are rejected. A rejected start sets err_o to 1, pulses done_o in the cycle after the start, and changes no PHY control output.
- R2: The lane count must be 1, 2 or 4. Any other count is rejected in the same way as R1, with err_o = 1, done_o pulsed and no control output changed.
- R3: An accepted start sets all four bits of tx_idle_o and tx_pd_o to 1 in the next cycle and clears err_o to 0. tx_mode_o and pll_pd_o then hold their previous values for the settle delay (SETTLE_US, 100 µs).
- R4: After the settle delay, tx_mode_o becomes 3 and pll_pd_o becomes 1. The divider and rate fields change only while pll_pd_o is 1.
- R5: For code 0, pll_div_o = 0x4380 and rate_sel_o = 1. For code 1, pll_div_o = 0x3840 and rate_sel_o = 0. At both rates rterm_o = 1, ref_div_o = 0, pll_ctl_o = 0x0800 and tx_ctl_o = 0.
- R6: With spread spectrum requested, ssc_depth_o = 9, ssc_en_o = 1 and ssc_cnt_o = 0x17D. Without it, only ssc_en_o is cleared, and depth and count keep their values.
- R7: At power-up, pll_pd_o goes to 0. The lowest N bits of tx_pd_o go to 0 for lane count N, and the other bits stay 1.
- R8: PLL ready is sampled at the end of each 100 µs poll interval, for at most 10 intervals (1000 µs). If it is never seen, err_o becomes 2 and done_o pulses. The lanes stay idle and tx_mode_o stays 3.
- R9: When ready is seen, tx_mode_o becomes 0 and the lowest N bits of tx_idle_o clear, in the same cycle as a done_o pulse with err_o = 0.
- R10: done_o lasts exactly one cycle. A start while a sequence is running is ignored: it gives no extra done_o and does not alter the result.
- R11: After reset, tx_idle_o = 0xF, tx_pd_o = 0xF, pll_pd_o = 1, tx_mode_o = 3, done_o = 0, err_o = 0, and all divider and spread-spectrum fields are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | One-cycle request to change rate |
| rate_i | input | 2 | Rate code (0: 1.62 Gb/s, 1: 2.7 Gb/s) |
| lanes_i | input | 3 | Active lane count |
| ssc_i | input | 1 | Spread-spectrum request |
| pll_ready_i | input | 1 | PLL lock indication |
| tx_idle_o | output | 4 | Per-lane idle controls |
| tx_pd_o | output | 4 | Per-lane power-down controls |
| pll_pd_o | output | 1 | PLL power-down |
| tx_mode_o | output | 2 | Transmit mode field |
| pll_div_o | output | 15 | PLL divider |
| rate_sel_o | output | 2 | Rate select field |
| rterm_o | output | 3 | Lane termination setting |
| ref_div_o | output | 4 | Reference divider |
| pll_ctl_o | output | 16 | Upper PLL control word |
| tx_ctl_o | output | 16 | Transmit control word |
| ssc_en_o | output | 1 | Spread-spectrum enable |
| ssc_depth_o | output | 4 | Spread-spectrum depth |
| ssc_cnt_o | output | 10 | Spread-spectrum count |
| done_o | output | 1 | One-cycle end-of-sequence pulse |
| err_o | output | 2 | Result: 0 none, 1 bad request, 2 PLL timeout |

## Verification
The assertions assume that pll_ready_i does nothing while the PLL is powered down. They also assume that start_i is a single-cycle pulse whose rate, lane and spread-spectrum values are stable in the cycle it is high. The bench's PLL model holds ready low whenever pll_pd_o is 1 and raises it a chosen number of cycles after pll_pd_o falls. Start is driven for exactly one cycle, with its fields, on the falling clock edge. Ready delays are set well inside the poll window, just before its last poll, or never, so each run reaches a definite outcome.

// File: rtl/lrs_pkg.sv
package lrs_pkg;
    localparam int unsigned LANE_CNT = 4;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SETTLE,
        ST_PROGRAM,
        ST_POWERUP,
        ST_POLL,
        ST_RELEASE,
        ST_FAIL
    } lrs_state_e;

    typedef enum logic [1:0] {
        ERR_NONE    = 2'd0,
        ERR_CONFIG  = 2'd1,
        ERR_TIMEOUT = 2'd2
    } lrs_err_e;

    typedef struct packed {
        logic [14:0] div;
        logic [1:0]  rsel;
        logic [2:0]  rterm;
        logic [3:0]  refdiv;
        logic [15:0] pllctl;
        logic [15:0] txctl;
    } lrs_rate_cfg_t;

    // Lowest n bits set, for lane counts 0..LANE_CNT.
    function automatic logic [LANE_CNT-1:0] lane_mask(input logic [2:0] n);
        logic [LANE_CNT:0] one_hot;
        one_hot = (LANE_CNT+1)'(1) << n;
        return LANE_CNT'(one_hot - 1'b1);
    endfunction
endpackage

// File: rtl/lrs_us_timer.sv
module lrs_us_timer #(
    parameter int unsigned PERIOD = 100
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    output logic tick
);
    localparam int unsigned W = (PERIOD > 1) ? $clog2(PERIOD) : 1;

    logic [W-1:0] cnt;

    assign tick = en && (cnt == W'(PERIOD - 1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt <= '0;
        else if (!en || tick)
            cnt <= '0;
        else
            cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/lrs_cfg_check.sv
module lrs_cfg_check (
    input  logic [1:0] rate,
    input  logic [2:0] lanes,
    output logic       ok
);
    logic rate_ok;
    logic lanes_ok;

    always_comb begin
        rate_ok  = (rate == 2'd0) || (rate == 2'd1);
        lanes_ok = (lanes == 3'd1) || (lanes == 3'd2) || (lanes == 3'd4);
        ok       = rate_ok && lanes_ok;
    end
endmodule

// File: rtl/lrs_rate_table.sv
module lrs_rate_table
    import lrs_pkg::*;
(
    input  logic [1:0]    rate,
    output lrs_rate_cfg_t cfg
);
    always_comb begin
        cfg.rterm  = 3'd1;
        cfg.refdiv = 4'd0;
        cfg.pllctl = 16'h0800;
        cfg.txctl  = 16'h0000;
        unique case (rate)
            2'd0: begin
                cfg.div  = 15'h4380;
                cfg.rsel = 2'd1;
            end
            default: begin
                cfg.div  = 15'h3840;
                cfg.rsel = 2'd0;
            end
        endcase
    end
endmodule

// File: rtl/lrs_seq.sv
module lrs_seq
    import lrs_pkg::*;
#(
    parameter int unsigned CYC_PER_US = 125,
    parameter int unsigned SETTLE_US  = 100,
    parameter int unsigned POLL_US    = 100,
    parameter int unsigned TIMEOUT_US = 1000
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        start_i,
    input  logic [1:0]  rate_i,
    input  logic [2:0]  lanes_i,
    input  logic        ssc_i,
    input  logic        pll_ready_i,
    output logic [3:0]  tx_idle_o,
    output logic [3:0]  tx_pd_o,
    output logic        pll_pd_o,
    output logic [1:0]  tx_mode_o,
    output logic [14:0] pll_div_o,
    output logic [1:0]  rate_sel_o,
    output logic [2:0]  rterm_o,
    output logic [3:0]  ref_div_o,
    output logic [15:0] pll_ctl_o,
    output logic [15:0] tx_ctl_o,
    output logic        ssc_en_o,
    output logic [3:0]  ssc_depth_o,
    output logic [9:0]  ssc_cnt_o,
    output logic        done_o,
    output logic [1:0]  err_o
);
    localparam int unsigned SETTLE_CYC = SETTLE_US * CYC_PER_US;
    localparam int unsigned POLL_CYC   = POLL_US * CYC_PER_US;
    localparam int unsigned POLL_MAX   = TIMEOUT_US / POLL_US;
    localparam int unsigned PW         = $clog2(POLL_MAX + 1);

    lrs_state_e    state, nxt;
    logic          cfg_ok;
    logic          settle_tick, poll_tick;
    logic [PW-1:0] poll_cnt;
    logic [1:0]    cap_rate;
    logic [2:0]    cap_lanes;
    logic          cap_ssc;
    lrs_rate_cfg_t rate_cfg;
    logic [3:0]    act_mask;

    lrs_cfg_check i_check (.rate(rate_i), .lanes(lanes_i), .ok(cfg_ok));
    lrs_rate_table i_table (.rate(cap_rate), .cfg(rate_cfg));

    lrs_us_timer #(.PERIOD(SETTLE_CYC)) i_settle_tmr (
        .clk(clk), .rst_n(rst_n), .en(state == ST_SETTLE), .tick(settle_tick));
    lrs_us_timer #(.PERIOD(POLL_CYC)) i_poll_tmr (
        .clk(clk), .rst_n(rst_n), .en(state == ST_POLL), .tick(poll_tick));

    assign act_mask = lane_mask(cap_lanes);

    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:    if (start_i && cfg_ok) nxt = ST_SETTLE;
            ST_SETTLE:  if (settle_tick) nxt = ST_PROGRAM;
            ST_PROGRAM: nxt = ST_POWERUP;
            ST_POWERUP: nxt = ST_POLL;
            ST_POLL: begin
                if (poll_tick) begin
                    if (pll_ready_i)
                        nxt = ST_RELEASE;
                    else if (poll_cnt == PW'(POLL_MAX - 1))
                        nxt = ST_FAIL;
                end
            end
            ST_RELEASE: nxt = ST_IDLE;
            ST_FAIL:    nxt = ST_IDLE;
            default:    nxt = ST_IDLE;
        endcase
    end

    // State register, with the poll counter that belongs to it.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            poll_cnt <= '0;
        end else begin
            state <= nxt;
            if (state != ST_POLL)
                poll_cnt <= '0;
            else if (poll_tick)
                poll_cnt <= poll_cnt + 1'b1;
        end
    end

    // Output and captured-request registers.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tx_idle_o   <= 4'hF;
            tx_pd_o     <= 4'hF;
            pll_pd_o    <= 1'b1;
            tx_mode_o   <= 2'd3;
            pll_div_o   <= '0;
            rate_sel_o  <= '0;
            rterm_o     <= '0;
            ref_div_o   <= '0;
            pll_ctl_o   <= '0;
            tx_ctl_o    <= '0;
            ssc_en_o    <= 1'b0;
            ssc_depth_o <= '0;
            ssc_cnt_o   <= '0;
            done_o      <= 1'b0;
            err_o       <= ERR_NONE;
            cap_rate    <= '0;
            cap_lanes   <= '0;
            cap_ssc     <= 1'b0;
        end else begin
            done_o <= 1'b0;
            unique case (state)
                ST_IDLE: begin
                    if (start_i) begin
                        if (cfg_ok) begin
                            tx_idle_o <= 4'hF;
                            tx_pd_o   <= 4'hF;
                            err_o     <= ERR_NONE;
                            cap_rate  <= rate_i;
                            cap_lanes <= lanes_i;
                            cap_ssc   <= ssc_i;
                        end else begin
                            err_o  <= ERR_CONFIG;
                            done_o <= 1'b1;
                        end
                    end
                end
                ST_SETTLE: begin
                    if (settle_tick) begin
                        tx_mode_o <= 2'd3;
                        pll_pd_o  <= 1'b1;
                    end
                end
                ST_PROGRAM: begin
                    pll_div_o  <= rate_cfg.div;
                    rate_sel_o <= rate_cfg.rsel;
                    rterm_o    <= rate_cfg.rterm;
                    ref_div_o  <= rate_cfg.refdiv;
                    pll_ctl_o  <= rate_cfg.pllctl;
                    tx_ctl_o   <= rate_cfg.txctl;
                    ssc_en_o   <= cap_ssc;
                    if (cap_ssc) begin
                        ssc_depth_o <= 4'd9;
                        ssc_cnt_o   <= 10'h17D;
                    end
                end
                ST_POWERUP: begin
                    pll_pd_o <= 1'b0;
                    tx_pd_o  <= ~act_mask;
                end
                ST_POLL: ;
                ST_RELEASE: begin
                    tx_mode_o <= 2'd0;
                    tx_idle_o <= ~act_mask;
                    done_o    <= 1'b1;
                end
                ST_FAIL: begin
                    err_o  <= ERR_TIMEOUT;
                    done_o <= 1'b1;
                end
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/lrs_seq_checker.sv
module lrs_seq_checker (
    input logic        clk,
    input logic        rst_n,
    input logic [3:0]  tx_idle_o,
    input logic [3:0]  tx_pd_o,
    input logic        pll_pd_o,
    input logic [1:0]  tx_mode_o,
    input logic [14:0] pll_div_o,
    input logic        ssc_en_o,
    input logic [3:0]  ssc_depth_o,
    input logic [9:0]  ssc_cnt_o,
    input logic        done_o,
    input logic [1:0]  err_o
);
    assert_done_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    assert_div_locked_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!pll_pd_o && $past(!pll_pd_o)) |-> $stable(pll_div_o));

    assert_mode_zero_pll_on_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_mode_o == 2'd0) |-> !pll_pd_o);

    assert_idle_needs_power_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ((~tx_idle_o) & tx_pd_o) == 4'h0);

    assert_ssc_values_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ssc_en_o |-> (ssc_depth_o == 4'd9 && ssc_cnt_o == 10'h17D));

    assert_timeout_keeps_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && err_o == 2'd2) |-> (tx_mode_o == 2'd3 && tx_idle_o == 4'hF));

    assert_err_with_done_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (err_o != $past(err_o) && err_o != 2'd0) |-> done_o);
endmodule

bind lrs_seq lrs_seq_checker i_lrs_seq_checker (
    .clk(clk), .rst_n(rst_n), .tx_idle_o(tx_idle_o), .tx_pd_o(tx_pd_o),
    .pll_pd_o(pll_pd_o), .tx_mode_o(tx_mode_o), .pll_div_o(pll_div_o),
    .ssc_en_o(ssc_en_o), .ssc_depth_o(ssc_depth_o), .ssc_cnt_o(ssc_cnt_o),
    .done_o(done_o), .err_o(err_o));

// File: tb/test_lrs_seq.sv
`timescale 1ns/1ps
module test_lrs_seq;
    localparam int CPU = 2;

    typedef struct {
        logic [1:0]  err;
        logic [3:0]  idle;
        logic [3:0]  pd;
        logic        pllpd;
        logic [1:0]  mode;
        logic [14:0] div;
        logic [1:0]  rsel;
        logic [2:0]  rterm;
        logic [3:0]  refdiv;
        logic [15:0] pllctl;
        logic [15:0] txctl;
        logic        sscen;
        logic [3:0]  sscdep;
        logic [9:0]  ssccnt;
    } exp_t;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start_i = 1'b0;
    logic [1:0] rate_i = '0;
    logic [2:0] lanes_i = '0;
    logic ssc_i = 1'b0;
    logic pll_ready_i;
    logic [3:0] tx_idle_o, tx_pd_o, ref_div_o, ssc_depth_o;
    logic pll_pd_o, ssc_en_o, done_o;
    logic [1:0] tx_mode_o, rate_sel_o, err_o;
    logic [14:0] pll_div_o;
    logic [2:0] rterm_o;
    logic [15:0] pll_ctl_o, tx_ctl_o;
    logic [9:0] ssc_cnt_o;

    int tests = 0;
    int fails = 0;
    int done_seen = 0;
    int pll_delay = 10;
    int pll_cnt = 0;
    exp_t exp_q[$];
    exp_t model;

    always #4 clk = ~clk;

    lrs_seq #(.CYC_PER_US(CPU)) i_lrs_seq (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .rate_i(rate_i),
        .lanes_i(lanes_i), .ssc_i(ssc_i), .pll_ready_i(pll_ready_i),
        .tx_idle_o(tx_idle_o), .tx_pd_o(tx_pd_o), .pll_pd_o(pll_pd_o),
        .tx_mode_o(tx_mode_o), .pll_div_o(pll_div_o), .rate_sel_o(rate_sel_o),
        .rterm_o(rterm_o), .ref_div_o(ref_div_o), .pll_ctl_o(pll_ctl_o),
        .tx_ctl_o(tx_ctl_o), .ssc_en_o(ssc_en_o), .ssc_depth_o(ssc_depth_o),
        .ssc_cnt_o(ssc_cnt_o), .done_o(done_o), .err_o(err_o));

    // PLL model: ready pll_delay cycles after power-up.
    always @(posedge clk) begin
        if (pll_pd_o) pll_cnt <= 0;
        else if (pll_cnt < 100000) pll_cnt <= pll_cnt + 1;
    end
    assign pll_ready_i = !pll_pd_o && (pll_cnt >= pll_delay);

    task automatic check(input string req, input string what, input int act, input int expv);
        tests++;
        if (act != expv) begin
            fails++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, expv);
        end
    endtask

    function automatic logic [3:0] mask_of(input int n);
        return 4'((1 << n) - 1);
    endfunction

    // Monitor: compare each done against the oldest expectation.
    always @(negedge clk) begin
        if (rst_n && done_o) begin
            done_seen++;
            if (exp_q.size() == 0) begin
                check("R10", "unexpected done", 1, 0);
            end else begin
                exp_t e;
                e = exp_q.pop_front();
                check("R1", "err", err_o, e.err);
                check("R9", "tx_idle", tx_idle_o, e.idle);
                check("R7", "tx_pd", tx_pd_o, e.pd);
                check("R7", "pll_pd", pll_pd_o, e.pllpd);
                check("R9", "tx_mode", tx_mode_o, e.mode);
                check("R5", "pll_div", pll_div_o, e.div);
                check("R5", "rate_sel", rate_sel_o, e.rsel);
                check("R5", "rterm", rterm_o, e.rterm);
                check("R5", "ref_div", ref_div_o, e.refdiv);
                check("R5", "pll_ctl", pll_ctl_o, e.pllctl);
                check("R5", "tx_ctl", tx_ctl_o, e.txctl);
                check("R6", "ssc_en", ssc_en_o, e.sscen);
                check("R6", "ssc_depth", ssc_depth_o, e.sscdep);
                check("R6", "ssc_cnt", ssc_cnt_o, e.ssccnt);
            end
        end
    end

    task automatic pulse_start(input logic [1:0] r, input logic [2:0] n, input logic s);
        @(negedge clk);
        rate_i = r; lanes_i = n; ssc_i = s; start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
    endtask

    task automatic wait_done(input int prev);
        while (done_seen == prev) @(negedge clk);
        repeat (3) @(negedge clk);
    endtask

    // Driver: build the expectation from the requirements, push, start.
    task automatic run_seq(input logic [1:0] r, input logic [2:0] n, input logic s,
                           input int delay, input bit expect_timeout);
        int prev;
        exp_t e;
        bit ok;
        ok = (r <= 2'd1) && (n == 3'd1 || n == 3'd2 || n == 3'd4);
        e = model;
        if (!ok) begin
            e.err = 2'd1;                         // R1/R2: nothing else moves
        end else begin
            e.div = (r == 2'd0) ? 15'h4380 : 15'h3840;
            e.rsel = (r == 2'd0) ? 2'd1 : 2'd0;
            e.rterm = 3'd1; e.refdiv = 4'd0; e.pllctl = 16'h0800; e.txctl = 16'h0;
            e.sscen = s;
            if (s) begin e.sscdep = 4'd9; e.ssccnt = 10'h17D; end
            e.pllpd = 1'b0;
            e.pd = ~mask_of(int'(n));
            if (expect_timeout) begin
                e.err = 2'd2; e.mode = 2'd3; e.idle = 4'hF;
            end else begin
                e.err = 2'd0; e.mode = 2'd0; e.idle = ~mask_of(int'(n));
            end
        end
        model = e;
        exp_q.push_back(e);
        pll_delay = delay;
        prev = done_seen;
        pulse_start(r, n, s);
        wait_done(prev);
    endtask

    initial begin
        model = '{err: 2'd0, idle: 4'hF, pd: 4'hF, pllpd: 1'b1, mode: 2'd3,
                  div: '0, rsel: '0, rterm: '0, refdiv: '0, pllctl: '0, txctl: '0,
                  sscen: 1'b0, sscdep: '0, ssccnt: '0};
        repeat (3) @(negedge clk);
        // R11: reset state
        check("R11", "reset idle", tx_idle_o, 4'hF);
        check("R11", "reset pd", tx_pd_o, 4'hF);
        check("R11", "reset pll_pd", pll_pd_o, 1);
        check("R11", "reset mode", tx_mode_o, 3);
        check("R11", "reset div", pll_div_o, 0);
        check("R11", "reset done/err", {done_o, err_o}, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // R5 R6 R9: 1.62 Gb/s, four lanes, spread spectrum, quick lock
        run_seq(2'd0, 3'd4, 1'b1, 10, 1'b0);

        // R3 R10: 2.7 Gb/s two lanes, no SSC; late lock on the last poll (R8 boundary)
        begin
            int prev;
            exp_t e;
            e = model;
            e.div = 15'h3840; e.rsel = 2'd0; e.sscen = 1'b0;
            e.pllpd = 1'b0; e.pd = 4'b1100; e.idle = 4'b1100; e.mode = 2'd0; e.err = 2'd0;
            model = e;
            exp_q.push_back(e);
            pll_delay = 1800;
            prev = done_seen;
            pulse_start(2'd1, 3'd2, 1'b0);
            repeat (100) @(negedge clk);
            check("R3", "parked idle", tx_idle_o, 4'hF);
            check("R3", "parked pd", tx_pd_o, 4'hF);
            check("R3", "mode held in settle", tx_mode_o, 0);
            check("R3", "pll on in settle", pll_pd_o, 0);
            pulse_start(2'd0, 3'd1, 1'b1);   // R10: ignored while busy
            repeat (150) @(negedge clk);
            check("R4", "mode after settle", tx_mode_o, 3);
            wait_done(prev);
        end

        // R1: bad rate codes; R2: bad lane counts
        run_seq(2'd2, 3'd4, 1'b0, 10, 1'b0);
        run_seq(2'd3, 3'd1, 1'b1, 10, 1'b0);
        run_seq(2'd0, 3'd3, 1'b0, 10, 1'b0);
        run_seq(2'd1, 3'd0, 1'b0, 10, 1'b0);

        // R8: PLL never locks, one lane
        run_seq(2'd0, 3'd1, 1'b0, 90000, 1'b1);

        // Recovery after timeout: 2.7 Gb/s four lanes with SSC
        run_seq(2'd1, 3'd4, 1'b1, 50, 1'b0);

        repeat (20) @(negedge clk);
        check("R10", "expectations left", exp_q.size(), 0);
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        tests++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule